// File: doc/BRIEF.md
# Two-Digit BCD Arithmetic Unit

This unit takes two operands, each written as two packed BCD digits (values 0 to 99), and a 4-bit operation select. It returns a four-digit packed BCD result that can drive a four-digit decimal display directly. The select uses the codes of the keys that choose an operation: one code each for add, subtract and multiply. Every other code gives zero.

Internally the operands are turned into binary and the operation is done in binary. A serial shift-and-add-3 converter then turns the 14-bit binary result back into four BCD digits. This converter takes one bit per clock, so there is no deep combinational decimal path. A caller pulses `start_i` while the unit is idle. `done_o` pulses once when the new result is on `result_o`, and the result then holds until the next operation completes. Subtraction assumes operand A is at least operand B, and operand digits are assumed to be valid BCD.

Top module: `bcd_arith_unit`

## Requirements
- R1: While `rst_ni` is low and after it is released, `result_o` is 16'h0000, and `done_o` and `busy_o` are 0 until a start is accepted.
- R2: With `op_sel_i` = 4'hF the result is the BCD encoding of A + B (largest result 0198).
- R3: With `op_sel_i` = 4'hE and A ≥ B the result is the BCD encoding of A − B.
- R4: With `op_sel_i` = 4'hD the result is the BCD encoding of A × B, up to 9801 for 99 × 99.
- R5: Any `op_sel_i` value other than 4'hF, 4'hE and 4'hD produces a result of 16'h0000.
- R6: Operands and result are packed BCD, with the least significant digit in bits [3:0]. Operand digit k is in bits [4k+3:4k], result digit k is in bits [4k+3:4k], and every result digit is in the range 0 to 9.
- R7: `done_o` is high for exactly one cycle. It rises 15 clock edges after the edge that accepts `start_i`: one capture cycle plus one load cycle plus 14 conversion cycles, with the first edge counted as the capture.
- R8: `busy_o` is high from the cycle after an accepted start until `done_o` rises. A start raised while `busy_o` is high is ignored: it does not change the result or the timing, and it produces no extra `done_o`.
- R9: `result_o` changes only in the cycle in which `done_o` is high. It holds its value between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation; taken only when not busy |
| op_sel_i | input | 4 | Operation code: F add, E subtract, D multiply |
| opd_a_i | input | 8 | Operand A, two packed BCD digits |
| opd_b_i | input | 8 | Operand B, two packed BCD digits |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse, new result valid |
| result_o | output | 16 | Result, four packed BCD digits |

## Verification
Multiplication is swept over every operand pair with A ≥ B. This reaches every carry between decimal digits and every result up to 9801, so it separates a faulty add-3 adjust or a wrong digit order from a correct conversion. Addition and subtraction are swept over all values of A, with B stepping through a spread of values, which exercises the digit carries and borrows both within a digit and across digits. Every non-arithmetic operation code is then applied to operands whose sum, difference and product are all nonzero, so a zero result shows the code was rejected rather than computed. Separate cases raise a second start in the middle of an operation and let the unit sit idle after a completion. Together with the latency measured on every operation, these show that the timing and the held result do not depend on stray starts.

// File: rtl/bcd_arith_pkg.sv
package bcd_arith_pkg;
  localparam logic [3:0] OP_ADD = 4'hF;
  localparam logic [3:0] OP_SUB = 4'hE;
  localparam logic [3:0] OP_MUL = 4'hD;

  typedef enum logic {ST_IDLE, ST_CALC} arith_state_e;
endpackage

// File: rtl/bcd_to_bin.sv
module bcd_to_bin #(
  parameter int DIGITS = 2,
  parameter int BIN_W  = 7
) (
  input  logic [4*DIGITS-1:0] bcd_i,
  output logic [BIN_W-1:0]    bin_o
);
  logic [BIN_W-1:0] acc;

  // Horner evaluation, most significant digit first
  always_comb begin
    acc = '0;
    for (int k = DIGITS - 1; k >= 0; k--) begin
      acc = acc * BIN_W'(10) + {{(BIN_W-4){1'b0}}, bcd_i[4*k +: 4]};
    end
  end

  assign bin_o = acc;
endmodule

// File: rtl/bin_alu.sv
module bin_alu
  import bcd_arith_pkg::*;
#(
  parameter int IN_W  = 7,
  parameter int OUT_W = 14
) (
  input  logic [IN_W-1:0]  a_i,
  input  logic [IN_W-1:0]  b_i,
  input  logic [3:0]       op_i,
  output logic [OUT_W-1:0] res_o
);
  logic [OUT_W-1:0] a_ext, b_ext;

  assign a_ext = OUT_W'(a_i);
  assign b_ext = OUT_W'(b_i);

  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = a_ext + b_ext;
      OP_SUB:  res_o = a_ext - b_ext;
      OP_MUL:  res_o = a_ext * b_ext;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/bin_to_bcd_seq.sv
module bin_to_bcd_seq #(
  parameter int BIN_W  = 14,
  parameter int DIGITS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [BIN_W-1:0]    bin_i,
  output logic                active_o,
  output logic                done_o,
  output logic [4*DIGITS-1:0] bcd_o
);
  localparam int BCD_W = 4 * DIGITS;
  localparam int CNT_W = $clog2(BIN_W + 1);

  logic [BIN_W-1:0] sh_q;
  logic [BCD_W-1:0] acc_q, adj, acc_nxt;
  logic [CNT_W-1:0] cnt_q;

  // add 3 to any digit of 5 or more before each shift
  for (genvar k = 0; k < DIGITS; k++) begin : g_adj
    assign adj[4*k +: 4] = (acc_q[4*k +: 4] >= 4'd5) ? acc_q[4*k +: 4] + 4'd3
                                                      : acc_q[4*k +: 4];
  end

  assign acc_nxt = {adj[BCD_W-2:0], sh_q[BIN_W-1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      acc_q    <= '0;
      cnt_q    <= '0;
      active_o <= 1'b0;
      done_o   <= 1'b0;
      bcd_o    <= '0;
    end else begin
      done_o <= 1'b0;
      if (load_i) begin
        sh_q     <= bin_i;
        acc_q    <= '0;
        cnt_q    <= CNT_W'(BIN_W);
        active_o <= 1'b1;
      end else if (active_o) begin
        sh_q  <= sh_q << 1;
        acc_q <= acc_nxt;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          active_o <= 1'b0;
          done_o   <= 1'b1;
          bcd_o    <= acc_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/bcd_arith_unit.sv
module bcd_arith_unit
  import bcd_arith_pkg::*;
#(
  parameter int DIGITS_IN  = 2,
  parameter int DIGITS_OUT = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [3:0]              op_sel_i,
  input  logic [4*DIGITS_IN-1:0]  opd_a_i,
  input  logic [4*DIGITS_IN-1:0]  opd_b_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [4*DIGITS_OUT-1:0] result_o
);
  localparam int OPB_W = $clog2(10 ** DIGITS_IN);
  localparam int RESB_W = $clog2(10 ** DIGITS_OUT);

  arith_state_e     state_q;
  logic [OPB_W-1:0] a_bin, b_bin, a_q, b_q;
  logic [3:0]       op_q;
  logic [RESB_W-1:0] alu_res;
  logic             conv_active, accept;

  bcd_to_bin #(.DIGITS(DIGITS_IN), .BIN_W(OPB_W)) u_cvt_a (
    .bcd_i(opd_a_i), .bin_o(a_bin)
  );
  bcd_to_bin #(.DIGITS(DIGITS_IN), .BIN_W(OPB_W)) u_cvt_b (
    .bcd_i(opd_b_i), .bin_o(b_bin)
  );

  assign busy_o = (state_q == ST_CALC) | conv_active;
  assign accept = start_i & ~busy_o;

  // operands captured in binary; the ALU works from registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      a_q     <= '0;
      b_q     <= '0;
      op_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          a_q     <= a_bin;
          b_q     <= b_bin;
          op_q    <= op_sel_i;
          state_q <= ST_CALC;
        end
        ST_CALC: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  bin_alu #(.IN_W(OPB_W), .OUT_W(RESB_W)) u_alu (
    .a_i(a_q), .b_i(b_q), .op_i(op_q), .res_o(alu_res)
  );

  bin_to_bcd_seq #(.BIN_W(RESB_W), .DIGITS(DIGITS_OUT)) u_dabble (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (state_q == ST_CALC),
    .bin_i    (alu_res),
    .active_o (conv_active),
    .done_o   (done_o),
    .bcd_o    (result_o)
  );
endmodule

// File: rtl/bcd_arith_unit_checker.sv
module bcd_arith_unit_checker #(
  parameter int DIGITS_OUT = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    start_i,
  input logic                    busy_o,
  input logic                    done_o,
  input logic [4*DIGITS_OUT-1:0] result_o
);
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));

  p_start_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  p_done_frees_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_result_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  for (genvar k = 0; k < DIGITS_OUT; k++) begin : g_dig
    p_digit_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      result_o[4*k +: 4] <= 4'd9);
  end
endmodule

bind bcd_arith_unit bcd_arith_unit_checker #(.DIGITS_OUT(DIGITS_OUT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
);

// File: tb/bcd_arith_unit_bench.sv
module bcd_arith_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LATENCY    = 15;
  localparam int WD_LIMIT   = 190000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  op_sel_i = 4'h0;
  logic [7:0]  opd_a_i = 8'h00;
  logic [7:0]  opd_b_i = 8'h00;
  logic        busy_o, done_o;
  logic [15:0] result_o;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;

  bcd_arith_unit u_bcd_arith_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_sel_i(op_sel_i),
    .opd_a_i(opd_a_i), .opd_b_i(opd_b_i), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles++;
    if (cycles >= WD_LIMIT) begin
      fails++;
      $display("FAIL watchdog R8: busy never cleared, actual=%0d cycles expected<%0d",
               cycles, WD_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  function automatic logic [7:0] enc2(int v);
    return {4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  function automatic logic [15:0] enc4(int v);
    return {4'((v / 1000) % 10), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // returns edges counted from the accepting edge until done_o was seen
  task automatic launch_wait(int a, int b, logic [3:0] op, output int n);
    opd_a_i  = enc2(a);
    opd_b_i  = enc2(b);
    op_sel_i = op;
    start_i  = 1'b1;
    @(posedge clk_i); #1;
    start_i = 1'b0;
    n = 0;
    while (n < 40) begin
      @(posedge clk_i); #1;
      n++;
      if (done_o) break;
    end
  endtask

  task automatic run_op(int a, int b, logic [3:0] op, string req);
    int n, exp;
    launch_wait(a, b, op, n);
    case (op)
      4'hF:    exp = a + b;
      4'hE:    exp = a - b;
      4'hD:    exp = a * b;
      default: exp = 0;
    endcase
    check(result_o == enc4(exp), req, int'(result_o), int'(enc4(exp)));
    check(n == LATENCY, "R7 latency", n, LATENCY);
  endtask

  initial begin
    int n;
    logic [15:0] held;
    #(3*CLK_PERIOD + 2);
    check(result_o == 16'h0 && !done_o && !busy_o, "R1 in reset",
          int'({busy_o, done_o, result_o}), 0);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check(result_o == 16'h0 && !done_o && !busy_o, "R1 after release",
          int'({busy_o, done_o, result_o}), 0);

    // R6 digit placement: 37 * 21 = 777, 12 + 9 = 0021
    run_op(37, 21, 4'hD, "R6 R4 digit order");
    run_op(12, 9, 4'hF, "R6 R2 digit order");

    // R4: every pair with A >= B, includes 99*99 = 9801
    for (int a = 0; a < 100; a++)
      for (int b = 0; b <= a; b++)
        run_op(a, b, 4'hD, "R4 multiply");

    // R2 and R3: all A, B spread
    for (int a = 0; a < 100; a++) begin
      for (int b = 0; b <= a; b += 5) begin
        run_op(a, b, 4'hF, "R2 add");
        run_op(a, b, 4'hE, "R3 subtract");
      end
      run_op(a, a, 4'hE, "R3 subtract equal");
    end
    run_op(99, 99, 4'hF, "R2 add max");

    // R5: every other code, operands chosen so add/sub/mul are all nonzero
    for (int c = 0; c < 13; c++)
      run_op(58, 23, 4'(c), "R5 unused code");

    // R8: second start while busy is ignored
    opd_a_i = enc2(45); opd_b_i = enc2(12); op_sel_i = 4'hD; start_i = 1'b1;
    @(posedge clk_i); #1;
    start_i = 1'b0;
    check(busy_o == 1'b1, "R8 busy after start", int'(busy_o), 1);
    repeat (4) @(posedge clk_i);
    #1;
    opd_a_i = enc2(99); opd_b_i = enc2(1); op_sel_i = 4'hF; start_i = 1'b1;
    @(posedge clk_i); #1;
    start_i = 1'b0;
    n = 5;
    while (!done_o && n < 40) begin
      @(posedge clk_i); #1;
      n++;
    end
    check(result_o == enc4(540), "R8 ignored start result", int'(result_o), int'(enc4(540)));
    check(n == LATENCY, "R8 ignored start latency", n, LATENCY);
    n = 0;
    for (int i = 0; i < 25; i++) begin
      @(posedge clk_i); #1;
      if (done_o) n++;
    end
    check(n == 0, "R8 no extra done", n, 0);

    // R9: result holds while idle with inputs changing
    held = result_o;
    opd_a_i = enc2(77); opd_b_i = enc2(66); op_sel_i = 4'hF;
    repeat (10) @(posedge clk_i);
    #1;
    check(result_o == held, "R9 hold idle", int'(result_o), int'(held));
    check(!done_o && !busy_o, "R9 idle flags", int'({busy_o, done_o}), 0);

    // R9: result holds during the next operation until done
    launch_wait(0, 0, 4'hF, n);
    check(result_o == 16'h0, "R9 next op result", int'(result_o), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  // R9: while an operation runs, the old value must stay
  logic [15:0] prev_res = 16'h0;
  always @(negedge clk_i) begin
    if (rst_ni && busy_o && !done_o && result_o != prev_res) begin
      vectors++;
      fails++;
      $display("FAIL R9 changed while busy actual=%h expected=%h", result_o, prev_res);
    end
    prev_res = result_o;
  end
endmodule